// File: doc/BRIEF.md
# Frame Start Watchdog with Retry

This block supervises a display sequencer through the single pulse that the sequencer produces at the start of every frame. An internal timebase divides the clock into frame periods whose length is set on a configuration input. A second counter tallies the frame periods that end without a start pulse. Every start pulse returns both counters to zero. When the tally reaches a programmable limit (7 in normal use), the block declares a stall and alerts the controller.

After a stall it tries to recover on its own. It drops the sequencer enable for a programmable number of cycles, raises it again and gives the sequencer a fresh window of the full limit to produce a pulse. A pulse at any point of a recovery attempt returns the block to plain monitoring and forgets the attempts made. If three attempts end without a pulse, the block enters emergency shutdown. The sequencer is then held disabled and an error record is latched. The record holds a sticky flag and the number of attempts made. Only reset leaves shutdown.

Top module: `frame_start_watchdog`

## Requirements
- R1: After reset, seq_en is 1, and alert, shutdown, err_flag and err_tries are all 0.
- R2: With no start pulse, a stall is declared on the (miss_limit × frame_len + 1)-th rising edge after reset release, counting the first edge with rst low as edge 1. On that edge alert rises and seq_en falls.
- R3: A start_pulse sampled high on a rising edge restarts the count. The next stall comes miss_limit × frame_len + 1 edges after that edge, so pulses spaced closer than that never cause a stall.
- R4: alert is high for exactly one cycle at each stall, including the stall that leads to shutdown.
- R5: After each stall, seq_en stays low for exactly off_len cycles (off_len ≥ 1) and then returns to 1. A full new window of miss_limit × frame_len + 1 edges begins on that edge.
- R6: When a third attempt's window expires without a pulse, shutdown rises on the same edge as alert. From that edge seq_en is held at 0.
- R7: A start_pulse sampled while seq_en is low for a retry, or during a re-enabled retry window, returns the block to monitoring. seq_en goes to 1 if it was low, and the attempt count goes back to zero, so the next stall starts again at attempt one.
- R8: shutdown stays at 1 and seq_en stays at 0 whatever start_pulse does. Only rst clears them.
- R9: On the edge where shutdown rises, err_flag becomes 1 and err_tries becomes 3. Both hold until reset.
- R10: A start_pulse sampled on the very edge that would declare a stall takes priority. No stall is declared and a new window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Frame start pulse from the sequencer, one cycle wide |
| frame_len | input | PERIOD_W | Frame period in clock cycles (≥ 1) |
| miss_limit | input | MISS_W | Missed frames that make a stall (≥ 1, normally 7) |
| off_len | input | OFF_W | Cycles the enable stays low per attempt (≥ 1) |
| seq_en | output | 1 | Sequencer enable |
| alert | output | 1 | One-cycle stall notice to the controller |
| shutdown | output | 1 | Latched emergency shutdown |
| err_flag | output | 1 | Sticky error record flag |
| err_tries | output | TRY_W | Attempts made when shutdown was entered |

## Verification
The frame timebase reaching the miss limit and a start pulse can fall in the same cycle. The bench provokes this by placing a pulse on exactly the edge that would otherwise declare a stall. It judges the result by the absence of any alert or enable change on that edge and by the next stall arriving one full window later. A second overlap places a pulse while the enable is held low for a retry. Here the recovery exit and the off-time count compete, and the enable must rise on the pulse edge instead of the end of the off time.

// File: rtl/fsw_pkg.sv
`timescale 1ns/1ps
package fsw_pkg;
  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RETRY = 2'd2,
    ST_DEAD  = 2'd3
  } fsw_state_e;
endpackage

// File: rtl/fsw_timebase.sv
`timescale 1ns/1ps
module fsw_timebase #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic [PERIOD_W-1:0] frame_len,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;

  assign tick = (cnt == frame_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fsw_miss_cnt.sv
`timescale 1ns/1ps
module fsw_miss_cnt #(
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              tick,
  input  logic [MISS_W-1:0] miss_limit,
  output logic              hit
);
  localparam logic [MISS_W-1:0] SAT = '1;
  logic [MISS_W-1:0] missed;

  assign hit = (missed == miss_limit);

  always_ff @(posedge clk) begin
    if (rst || clear)
      missed <= '0;
    else if (tick && missed != SAT)
      missed <= missed + 1'b1;
  end
endmodule

// File: rtl/fsw_retry_fsm.sv
`timescale 1ns/1ps
module fsw_retry_fsm
  import fsw_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int MAX_TRY = 3,
  parameter int TRY_W   = $clog2(MAX_TRY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pulse,
  input  logic             hit,
  input  logic [OFF_W-1:0] off_len,
  output logic             restart,
  output logic             seq_en,
  output logic             alert,
  output logic             shutdown,
  output logic             err_flag,
  output logic [TRY_W-1:0] err_tries
);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRY);

  fsw_state_e       state;
  logic [TRY_W-1:0] tries;
  logic [OFF_W-1:0] off_cnt;

  assign restart = (state == ST_HOLD) || (state == ST_DEAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WATCH;
      tries     <= '0;
      off_cnt   <= '0;
      seq_en    <= 1'b1;
      alert     <= 1'b0;
      shutdown  <= 1'b0;
      err_flag  <= 1'b0;
      err_tries <= '0;
    end else begin
      alert <= 1'b0;
      case (state)
        ST_WATCH: begin
          if (!start_pulse && hit) begin
            state   <= ST_HOLD;
            tries   <= TRY_W'(1);
            off_cnt <= '0;
            seq_en  <= 1'b0;
            alert   <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (start_pulse) begin
            state  <= ST_WATCH;
            tries  <= '0;
            seq_en <= 1'b1;
          end else if (off_cnt == off_len - 1'b1) begin
            state  <= ST_RETRY;
            seq_en <= 1'b1;
          end else begin
            off_cnt <= off_cnt + 1'b1;
          end
        end
        ST_RETRY: begin
          if (start_pulse) begin
            state <= ST_WATCH;
            tries <= '0;
          end else if (hit) begin
            alert  <= 1'b1;
            seq_en <= 1'b0;
            if (tries == LAST_TRY) begin
              state     <= ST_DEAD;
              shutdown  <= 1'b1;
              err_flag  <= 1'b1;
              err_tries <= tries;
            end else begin
              state   <= ST_HOLD;
              tries   <= tries + 1'b1;
              off_cnt <= '0;
            end
          end
        end
        default: begin
          seq_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/frame_start_watchdog.sv
`timescale 1ns/1ps
module frame_start_watchdog #(
  parameter int PERIOD_W = 16,
  parameter int MISS_W   = 4,
  parameter int OFF_W    = 8,
  parameter int MAX_TRY  = 3,
  parameter int TRY_W    = $clog2(MAX_TRY + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_pulse,
  input  logic [PERIOD_W-1:0] frame_len,
  input  logic [MISS_W-1:0]   miss_limit,
  input  logic [OFF_W-1:0]    off_len,
  output logic                seq_en,
  output logic                alert,
  output logic                shutdown,
  output logic                err_flag,
  output logic [TRY_W-1:0]    err_tries
);
  logic tick;
  logic hit;
  logic restart;
  logic clear;

  assign clear = start_pulse || restart;

  fsw_timebase #(.PERIOD_W(PERIOD_W)) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .frame_len (frame_len),
    .tick      (tick)
  );

  fsw_miss_cnt #(.MISS_W(MISS_W)) u_miss (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .tick       (tick),
    .miss_limit (miss_limit),
    .hit        (hit)
  );

  fsw_retry_fsm #(
    .OFF_W   (OFF_W),
    .MAX_TRY (MAX_TRY),
    .TRY_W   (TRY_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_pulse (start_pulse),
    .hit         (hit),
    .off_len     (off_len),
    .restart     (restart),
    .seq_en      (seq_en),
    .alert       (alert),
    .shutdown    (shutdown),
    .err_flag    (err_flag),
    .err_tries   (err_tries)
  );
endmodule

// File: rtl/frame_start_watchdog_chk.sv
`timescale 1ns/1ps
module frame_start_watchdog_chk #(
  parameter int MAX_TRY = 3,
  parameter int TRY_W   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_pulse,
  input logic             seq_en,
  input logic             alert,
  input logic             shutdown,
  input logic             err_flag,
  input logic [TRY_W-1:0] err_tries
);
  assert_alert_single_R4: assert property (@(posedge clk) disable iff (rst)
    alert |=> !alert);

  assert_fall_with_alert_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_en) |-> alert);

  assert_shutdown_disables_R6: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> !seq_en);

  assert_shutdown_latched_R8: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (shutdown && !seq_en));

  assert_log_at_shutdown_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> (err_flag && err_tries == TRY_W'(MAX_TRY) && alert));

  assert_flag_only_with_shutdown_R9: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> shutdown);
endmodule

bind frame_start_watchdog frame_start_watchdog_chk #(
  .MAX_TRY (MAX_TRY),
  .TRY_W   (TRY_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_pulse (start_pulse),
  .seq_en      (seq_en),
  .alert       (alert),
  .shutdown    (shutdown),
  .err_flag    (err_flag),
  .err_tries   (err_tries)
);

// File: tb/frame_start_watchdog_test.sv
`timescale 1ns/1ps
module frame_start_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int MW = 4;
  localparam int OW = 8;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_pulse = 1'b0;
  logic [PW-1:0] frame_len = 16'd4;
  logic [MW-1:0] miss_limit = 4'd7;
  logic [OW-1:0] off_len = 8'd3;
  logic          seq_en, alert, shutdown, err_flag;
  logic [TW-1:0] err_tries;

  frame_start_watchdog uut (
    .clk(clk), .rst(rst), .start_pulse(start_pulse),
    .frame_len(frame_len), .miss_limit(miss_limit), .off_len(off_len),
    .seq_en(seq_en), .alert(alert), .shutdown(shutdown),
    .err_flag(err_flag), .err_tries(err_tries)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  typedef enum int {EV_ALERT, EV_EN_FALL, EV_EN_RISE, EV_SHUT} ev_e;
  typedef struct {
    int    at;
    ev_e   kind;
    string req;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;

  task automatic expect_ev(int at, ev_e kind, string req);
    exp_t e;
    e.at = at; e.kind = kind; e.req = req;
    sb.push_back(e);
  endtask

  task automatic see(ev_e kind);
    exp_t e;
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL R3: unexpected event %s at cycle %0d, expected none", kind.name(), cyc);
    end else begin
      e = sb.pop_front();
      if (e.at != cyc || e.kind != kind) begin
        errors++;
        $display("FAIL %s: actual %s at cycle %0d, expected %s at cycle %0d",
                 e.req, kind.name(), cyc, e.kind.name(), e.at);
      end
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: turns output changes into events and pops the scoreboard
  logic p_alert = 1'b0, p_en = 1'b1, p_shut = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      p_alert = 1'b0; p_en = 1'b1; p_shut = 1'b0;
    end else begin
      if (alert && !p_alert)  see(EV_ALERT);
      if (!seq_en && p_en)    see(EV_EN_FALL);
      if (seq_en && !p_en)    see(EV_EN_RISE);
      if (shutdown && !p_shut) see(EV_SHUT);
      p_alert = alert; p_en = seq_en; p_shut = shutdown;
    end
  end

  task automatic do_reset(int p, int l, int o);
    rst = 1'b1;
    start_pulse = 1'b0;
    frame_len = PW'(p); miss_limit = MW'(l); off_len = OW'(o);
    sb.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // drive a pulse so that it is sampled on edge e
  task automatic pulse_at(int e);
    wait_to(e - 1);
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual run still going, expected finish");
    summary();
    $finish;
  end

  initial begin
    // Scenario A: full escalation, period 4, limit 7, off 3
    do_reset(4, 7, 3);
    chk("R1 seq_en", int'(seq_en), 1);
    chk("R1 alert", int'(alert), 0);
    chk("R1 shutdown", int'(shutdown), 0);
    chk("R1 err_flag", int'(err_flag), 0);
    chk("R1 err_tries", int'(err_tries), 0);
    expect_ev(29, EV_ALERT, "R2");   expect_ev(29, EV_EN_FALL, "R2");
    expect_ev(32, EV_EN_RISE, "R5");
    expect_ev(61, EV_ALERT, "R4");   expect_ev(61, EV_EN_FALL, "R5");
    expect_ev(64, EV_EN_RISE, "R5");
    expect_ev(93, EV_ALERT, "R4");   expect_ev(93, EV_EN_FALL, "R5");
    expect_ev(96, EV_EN_RISE, "R5");
    expect_ev(125, EV_ALERT, "R6");  expect_ev(125, EV_EN_FALL, "R6");
    expect_ev(125, EV_SHUT, "R6");
    wait_to(30);
    chk("R4 alert one cycle", int'(alert), 0);
    wait_to(124);
    chk("R9 no flag before shutdown", int'(err_flag), 0);
    wait_to(125);
    chk("R9 err_flag", int'(err_flag), 1);
    chk("R9 err_tries", int'(err_tries), 3);
    pulse_at(130);
    wait_to(160);
    chk("R8 shutdown held", int'(shutdown), 1);
    chk("R8 seq_en held low", int'(seq_en), 0);
    chk("R9 err_tries held", int'(err_tries), 3);
    chk("R6 scoreboard drained", sb.size(), 0);
    do_reset(4, 7, 3);
    chk("R8 reset clears shutdown", int'(shutdown), 0);
    chk("R8 reset restores seq_en", int'(seq_en), 1);

    // Scenario B: period 6, limit 5, off 2, pulses 25 apart
    do_reset(6, 5, 2);
    expect_ev(151, EV_ALERT, "R3");  expect_ev(151, EV_EN_FALL, "R3");
    expect_ev(153, EV_EN_RISE, "R5");
    for (int k = 0; k < 5; k++) pulse_at(20 + 25 * k);
    wait_to(150);
    chk("R3 no stall while pulsing", int'(seq_en), 1);
    wait_to(160);
    chk("R3 scoreboard drained", sb.size(), 0);

    // Scenario C: pulse in a re-enabled retry window
    do_reset(4, 7, 3);
    expect_ev(29, EV_ALERT, "R2");   expect_ev(29, EV_EN_FALL, "R2");
    expect_ev(32, EV_EN_RISE, "R5");
    expect_ev(69, EV_ALERT, "R7");   expect_ev(69, EV_EN_FALL, "R7");
    expect_ev(72, EV_EN_RISE, "R7");
    expect_ev(101, EV_ALERT, "R7");  expect_ev(101, EV_EN_FALL, "R7");
    expect_ev(104, EV_EN_RISE, "R7");
    expect_ev(133, EV_ALERT, "R7");  expect_ev(133, EV_EN_FALL, "R7");
    expect_ev(136, EV_EN_RISE, "R7");
    expect_ev(165, EV_ALERT, "R7");  expect_ev(165, EV_EN_FALL, "R7");
    expect_ev(165, EV_SHUT, "R7");
    pulse_at(40);
    wait_to(164);
    chk("R7 no early shutdown", int'(shutdown), 0);
    wait_to(170);
    chk("R7 shutdown after three fresh tries", int'(shutdown), 1);
    chk("R7 scoreboard drained", sb.size(), 0);

    // Scenario D: pulse on the stall edge, then pulse while enable is low
    do_reset(4, 7, 3);
    expect_ev(58, EV_ALERT, "R10");  expect_ev(58, EV_EN_FALL, "R10");
    expect_ev(59, EV_EN_RISE, "R7");
    expect_ev(88, EV_ALERT, "R7");   expect_ev(88, EV_EN_FALL, "R7");
    expect_ev(91, EV_EN_RISE, "R5");
    pulse_at(29);
    wait_to(30);
    chk("R10 pulse wins over stall", int'(seq_en), 1);
    pulse_at(59);
    wait_to(95);
    chk("R10 scoreboard drained", sb.size(), 0);
    chk("R7 no shutdown", int'(shutdown), 0);

    summary();
    $finish;
  end
endmodule